// File: doc/BRIEF.md
# IDE DMA Transfer Sequencer

This block is the control state machine that carries one IDE DMA command across a series of DMA chunks handed out by a descriptor-driven channel. When a command starts, it latches the command type and the device kind and loads the byte count still to be moved. For a disk this count is the sector count times 512. For a packet (optical) device it is the packet transfer size. Each time the channel reports that a chunk is complete, the sequencer takes one of several actions:

- end the command with a final status and an interrupt;
- park in a stalled state until the channel is restarted;
- request sector work for the new chunk;
- take the error path.

The block moves no data. It tells a data mover what to do through a one-cycle sector-work request, which carries the sector count and the direction. For a non-block packet transfer it issues a direct-copy request with a byte length instead. It tells the DMA channel that a chunk is finished through a one-cycle end-of-chunk pulse. The drive interrupt stays high until software reads the status.

Top module: `ide_dma_seq`

## Requirements
- R1: In reset, status is 0x00 and irq, active, waiting and every pulse output are 0. An accepted start (start_i while inactive) sets status to busy (0x80) and sets active. It loads sectors_left with sector_cnt_i and loads the remaining byte count with sector_cnt_i×512 for a disk (packet_i=0) or with pkt_size_i for a packet device. A start is accepted even if chunk_valid_i is high in the same cycle, and that completion is dropped.
- R2: A start that arrives while active changes nothing. The latched command, sector count and remaining bytes stay as they were.
- R3: A completion with chunk_err_i=1 is handled first, whatever the other state. It sets status to 0x41, raises irq, clears active and remaining bytes, and pulses chunk_end_o.
- R4: An error-free completion while inactive sets waiting_o. It gives no end-of-chunk pulse and leaves irq and status unchanged. The next accepted start clears waiting_o.
- R5: An active completion whose remaining byte count is zero or negative finishes the command. It sets status to 0x50 for a disk or 0x40 for a packet device, raises irq, clears active and pulses chunk_end_o.
- R6: An active completion with chunk_len_i=0, when bytes still remain, pulses chunk_end_o and changes nothing else.
- R7: Otherwise, for a read (cmd 0 or 3) or a write (cmd 1), the block issues work_req_o with work_nsec_o = ceil(len/512) and subtracts len from the remaining bytes. work_write_o is 1 only for a disk write. No end-of-chunk pulse is given.
- R8: For a disk, sectors_left_o drops by ceil(len/512), modulo 2^16, on each such chunk. A trim command (cmd 2) on a disk takes the same counts but issues no work request and pulses chunk_end_o instead.
- R9: A packet device always requests read work, whatever the command code, and never decrements sectors_left_o.
- R10: For a packet device started with an LBA of all ones, a completion with bytes remaining and a nonzero length issues copy_req_o with copy_len_o = min(remaining, len). It then sets status 0x40, raises irq, clears active and remaining bytes, and pulses chunk_end_o.
- R11: irq_o stays high until a cycle with status_rd_i=1. It falls on the following edge unless a new final status is set in that same cycle, in which case it stays high.
- R12: chunk_end_o, work_req_o and copy_req_o are one-cycle pulses, each appearing only in the cycle after a completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a DMA command |
| cmd_i | input | 2 | 0/3 read, 1 write, 2 trim |
| packet_i | input | 1 | 1 = packet device, 0 = disk |
| sector_cnt_i | input | 16 | Disk sector count at start |
| pkt_size_i | input | 25 | Packet transfer size in bytes at start |
| pkt_lba_i | input | 32 | Packet LBA; all ones marks a non-block transfer |
| chunk_valid_i | input | 1 | Chunk-completion event |
| chunk_len_i | input | 16 | Chunk length in bytes |
| chunk_err_i | input | 1 | Completion carries an error |
| status_rd_i | input | 1 | Status read, acknowledges irq |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Drive interrupt |
| active_o | output | 1 | Command in progress |
| waiting_o | output | 1 | Stalled until restart |
| chunk_end_o | output | 1 | End-of-chunk pulse to the channel |
| work_req_o | output | 1 | Sector-work request pulse |
| work_write_o | output | 1 | Direction of the last work request |
| work_nsec_o | output | 16 | Sectors of the last work request |
| copy_req_o | output | 1 | Direct-copy request pulse |
| copy_len_o | output | 16 | Bytes of the last direct copy |
| sectors_left_o | output | 16 | Drive sector count remaining |

## Verification
Disk reads run with chunk lengths that are whole sectors, lengths that are not multiples of 512, and zero lengths. These separate ceiling rounding from truncation, and dispatching work from ending a chunk. Writes and trims reuse the same chunk sizes, so that only the direction flag and the presence of the work pulse differ. Packet commands are run twice: once with a normal LBA, to show that reads are always requested and the sector count is left alone, and once with an all-ones LBA and sizes on both sides of the chunk length, to show both arms of the minimum. Errors, completions while idle, starts while active, and a status read that coincides with a new interrupt probe the priority order.

// File: rtl/ide_dma_seq_pkg.sv
// Shared types for the IDE DMA transfer sequencer.
// Assumes: status bit 7 busy, bit 6 ready, bit 4 seek complete, bit 0 error.
package ide_dma_seq_pkg;

    // Command codes as presented on cmd_i
    localparam logic [1:0] CMD_WRITE = 2'd1;
    localparam logic [1:0] CMD_TRIM  = 2'd2;

    // Final and intermediate status bytes
    localparam logic [7:0] STAT_RESET   = 8'h00;
    localparam logic [7:0] STAT_BUSY    = 8'h80;
    localparam logic [7:0] STAT_DISK_OK = 8'h50;
    localparam logic [7:0] STAT_PKT_OK  = 8'h40;
    localparam logic [7:0] STAT_FAULT   = 8'h41;

    // Outcome of one chunk-completion event
    typedef enum logic [2:0] {
        EV_NONE,
        EV_FAULT,
        EV_STALL,
        EV_FINISH,
        EV_EMPTY,
        EV_COPY,
        EV_TRIM,
        EV_WORK
    } chunk_ev_e;

endpackage

// File: rtl/ide_dma_classify.sv
// Decides what one chunk-completion event means.
// Purely combinational; the priority order is error, inactive,
// nothing left, empty chunk, non-block copy, trim, sector work.
// Assumes evt_i is already masked off in a cycle where a start is taken.
module ide_dma_classify
    import ide_dma_seq_pkg::*;
(
    input  logic      evt_i,
    input  logic      err_i,
    input  logic      active_i,
    input  logic      rem_pos_i,
    input  logic      len_zero_i,
    input  logic      packet_i,
    input  logic      nonblock_i,
    input  logic      trim_i,
    output chunk_ev_e ev_o
);

    // Priority decision for the current completion
    always_comb begin
        if (!evt_i)                      ev_o = EV_NONE;
        else if (err_i)                  ev_o = EV_FAULT;
        else if (!active_i)              ev_o = EV_STALL;
        else if (!rem_pos_i)             ev_o = EV_FINISH;
        else if (len_zero_i)             ev_o = EV_EMPTY;
        else if (packet_i && nonblock_i) ev_o = EV_COPY;
        else if (!packet_i && trim_i)    ev_o = EV_TRIM;
        else                             ev_o = EV_WORK;
    end

endmodule

// File: rtl/ide_dma_count.sv
// Byte and sector accounting for one command.
// Holds the signed remaining byte count and the drive sector count,
// derives the rounded-up sector count of a chunk and the copy length.
// Assumes SHIFT is log2 of the sector size.
module ide_dma_count
    import ide_dma_seq_pkg::*;
#(
    parameter int SEC_W = 16,
    parameter int LEN_W = 16,
    parameter int SHIFT = 9,
    localparam int BYTE_W = SEC_W + SHIFT
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              start_i,
    input  logic              active_i,
    input  logic              packet_i,
    input  logic              packet_q_i,
    input  logic [SEC_W-1:0]  sector_cnt_i,
    input  logic [BYTE_W-1:0] pkt_size_i,
    input  chunk_ev_e         ev_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              rem_pos_o,
    output logic [LEN_W-1:0]  nsec_o,
    output logic [LEN_W-1:0]  copy_len_o,
    output logic [SEC_W-1:0]  sectors_o
);

    localparam int REM_W     = BYTE_W + 1;
    localparam int SEC_BYTES = 1 << SHIFT;

    logic signed [REM_W-1:0] rem_q;
    logic signed [REM_W-1:0] len_ext;
    logic        [LEN_W:0]   len_round;

    // Rounded-up sector count and signed length for this chunk
    always_comb begin
        len_round  = {1'b0, len_i} + (LEN_W+1)'(SEC_BYTES - 1);
        nsec_o     = LEN_W'(len_round >> SHIFT);
        len_ext    = $signed(REM_W'(len_i));
        rem_pos_o  = !rem_q[REM_W-1] && (rem_q != '0);
        copy_len_o = (rem_q < len_ext) ? LEN_W'(rem_q) : len_i;
    end

    // Remaining byte count: load, consume per chunk, clear on fault or copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= packet_i ? $signed(REM_W'(pkt_size_i))
                              : $signed(REM_W'({sector_cnt_i, {SHIFT{1'b0}}}));
        end else if (ev_i == EV_FAULT || ev_i == EV_COPY) begin
            rem_q <= '0;
        end else if (ev_i == EV_WORK || ev_i == EV_TRIM) begin
            rem_q <= rem_q - len_ext;
        end
    end

    // Drive sector count: load, reduce by rounded sectors on disk chunks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sectors_o <= '0;
        end else if (load_i) begin
            sectors_o <= sector_cnt_i;
        end else if ((ev_i == EV_WORK && !packet_q_i) || ev_i == EV_TRIM) begin
            sectors_o <= sectors_o - SEC_W'(nsec_o);
        end
    end

    // R2: a start while active with no completion leaves the counts alone
    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && start_i && ev_i == EV_NONE) |=> ($stable(sectors_o) && $stable(rem_q)));

endmodule

// File: rtl/ide_dma_report.sv
// Status byte, interrupt and request pulses towards the channel and mover.
// All outputs are registered; pulses last one cycle.
// Assumes at most one outcome per cycle from the classifier.
module ide_dma_report
    import ide_dma_seq_pkg::*;
#(
    parameter int LEN_W = 16
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  chunk_ev_e        ev_i,
    input  logic             packet_i,
    input  logic             write_i,
    input  logic [LEN_W-1:0] nsec_i,
    input  logic [LEN_W-1:0] copy_len_i,
    input  logic             status_rd_i,
    output logic [7:0]       status_o,
    output logic             irq_o,
    output logic             chunk_end_o,
    output logic             work_req_o,
    output logic             work_write_o,
    output logic [LEN_W-1:0] work_nsec_o,
    output logic             copy_req_o,
    output logic [LEN_W-1:0] copy_len_o
);

    logic irq_set;
    logic end_chunk;

    // Which outcomes raise the interrupt and which end the chunk
    always_comb begin
        irq_set   = (ev_i == EV_FAULT) || (ev_i == EV_FINISH) || (ev_i == EV_COPY);
        end_chunk = irq_set || (ev_i == EV_EMPTY) || (ev_i == EV_TRIM);
    end

    // Status byte: busy on start, final value on each terminating outcome
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= STAT_RESET;
        end else if (load_i) begin
            status_o <= STAT_BUSY;
        end else begin
            case (ev_i)
                EV_FAULT:  status_o <= STAT_FAULT;
                EV_FINISH: status_o <= packet_i ? STAT_PKT_OK : STAT_DISK_OK;
                EV_COPY:   status_o <= STAT_PKT_OK;
                default:   status_o <= status_o;
            endcase
        end
    end

    // Interrupt: set wins over the acknowledge of a status read
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= irq_set || (irq_o && !status_rd_i);
    end

    // One-cycle pulses and the parameters they carry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chunk_end_o  <= 1'b0;
            work_req_o   <= 1'b0;
            work_write_o <= 1'b0;
            work_nsec_o  <= '0;
            copy_req_o   <= 1'b0;
            copy_len_o   <= '0;
        end else begin
            chunk_end_o <= end_chunk;
            work_req_o  <= (ev_i == EV_WORK);
            copy_req_o  <= (ev_i == EV_COPY);
            if (ev_i == EV_WORK) begin
                work_write_o <= write_i && !packet_i;
                work_nsec_o  <= nsec_i;
            end
            if (ev_i == EV_COPY) begin
                copy_len_o <= copy_len_i;
            end
        end
    end

    // R11: a status read with no new final status drops the interrupt
    assert_irq_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd_i && ev_i == EV_NONE) |=> !irq_o);

endmodule

// File: rtl/ide_dma_seq.sv
// IDE DMA transfer sequencer top.
// Latches the command on an accepted start, keeps the active and stalled
// flags, and ties the classifier, the byte/sector counters and the
// reporting stage together. Assumes one completion event per cycle at most.
module ide_dma_seq
    import ide_dma_seq_pkg::*;
#(
    parameter int SEC_W = 16,
    parameter int LEN_W = 16,
    parameter int SHIFT = 9,
    parameter int LBA_W = 32,
    localparam int BYTE_W = SEC_W + SHIFT
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        cmd_i,
    input  logic              packet_i,
    input  logic [SEC_W-1:0]  sector_cnt_i,
    input  logic [BYTE_W-1:0] pkt_size_i,
    input  logic [LBA_W-1:0]  pkt_lba_i,
    input  logic              chunk_valid_i,
    input  logic [LEN_W-1:0]  chunk_len_i,
    input  logic              chunk_err_i,
    input  logic              status_rd_i,
    output logic [7:0]        status_o,
    output logic              irq_o,
    output logic              active_o,
    output logic              waiting_o,
    output logic              chunk_end_o,
    output logic              work_req_o,
    output logic              work_write_o,
    output logic [LEN_W-1:0]  work_nsec_o,
    output logic              copy_req_o,
    output logic [LEN_W-1:0]  copy_len_o,
    output logic [SEC_W-1:0]  sectors_left_o
);

    logic             load;
    logic             evt;
    logic             write_q;
    logic             trim_q;
    logic             packet_q;
    logic             nonblock_q;
    logic             rem_pos;
    logic [LEN_W-1:0] nsec;
    logic [LEN_W-1:0] copy_len;
    chunk_ev_e        ev;

    // Start is taken only when idle; it masks a completion in the same cycle
    always_comb begin
        load = start_i && !active_o;
        evt  = chunk_valid_i && !load;
    end

    // Command latch, taken on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q    <= 1'b0;
            trim_q     <= 1'b0;
            packet_q   <= 1'b0;
            nonblock_q <= 1'b0;
        end else if (load) begin
            write_q    <= (cmd_i == CMD_WRITE);
            trim_q     <= (cmd_i == CMD_TRIM);
            packet_q   <= packet_i;
            nonblock_q <= packet_i && (&pkt_lba_i);
        end
    end

    // Active and stalled flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o  <= 1'b0;
            waiting_o <= 1'b0;
        end else begin
            if (load)
                active_o <= 1'b1;
            else if (ev == EV_FAULT || ev == EV_FINISH || ev == EV_COPY)
                active_o <= 1'b0;
            if (load)
                waiting_o <= 1'b0;
            else if (ev == EV_STALL)
                waiting_o <= 1'b1;
        end
    end

    ide_dma_classify i_classify (
        .evt_i      (evt),
        .err_i      (chunk_err_i),
        .active_i   (active_o),
        .rem_pos_i  (rem_pos),
        .len_zero_i (chunk_len_i == '0),
        .packet_i   (packet_q),
        .nonblock_i (nonblock_q),
        .trim_i     (trim_q),
        .ev_o       (ev)
    );

    ide_dma_count #(
        .SEC_W (SEC_W),
        .LEN_W (LEN_W),
        .SHIFT (SHIFT)
    ) i_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .start_i      (start_i),
        .active_i     (active_o),
        .packet_i     (packet_i),
        .packet_q_i   (packet_q),
        .sector_cnt_i (sector_cnt_i),
        .pkt_size_i   (pkt_size_i),
        .ev_i         (ev),
        .len_i        (chunk_len_i),
        .rem_pos_o    (rem_pos),
        .nsec_o       (nsec),
        .copy_len_o   (copy_len),
        .sectors_o    (sectors_left_o)
    );

    ide_dma_report #(
        .LEN_W (LEN_W)
    ) i_report (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .ev_i         (ev),
        .packet_i     (packet_q),
        .write_i      (write_q),
        .nsec_i       (nsec),
        .copy_len_i   (copy_len),
        .status_rd_i  (status_rd_i),
        .status_o     (status_o),
        .irq_o        (irq_o),
        .chunk_end_o  (chunk_end_o),
        .work_req_o   (work_req_o),
        .work_write_o (work_write_o),
        .work_nsec_o  (work_nsec_o),
        .copy_req_o   (copy_req_o),
        .copy_len_o   (copy_len_o)
    );

    // R12: an end-of-chunk pulse only follows a completion event
    assert_end_after_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_end_o |-> $past(chunk_valid_i));

    // R4: an error-free completion while idle stalls without ending the chunk
    assert_stall_no_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && chunk_valid_i && !start_i && !chunk_err_i) |=> (waiting_o && !chunk_end_o));

    // R8: a disk trim never produces a work request
    assert_trim_no_work_R8: assert property (@(posedge clk) disable iff (!rst_n)
        work_req_o |-> !(trim_q && !packet_q));

    // R5: whenever the interrupt rises, the command is no longer active
    assert_irq_inactive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> !active_o);

    // R1: the active flag rises together with the busy status
    assert_busy_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> (status_o == STAT_BUSY));

endmodule

// File: tb/test_ide_dma_seq.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module test_ide_dma_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  cmd_i = 2'd0;
    logic        packet_i = 1'b0;
    logic [15:0] sector_cnt_i = '0;
    logic [24:0] pkt_size_i = '0;
    logic [31:0] pkt_lba_i = '0;
    logic        chunk_valid_i = 1'b0;
    logic [15:0] chunk_len_i = '0;
    logic        chunk_err_i = 1'b0;
    logic        status_rd_i = 1'b0;
    logic [7:0]  status_o;
    logic        irq_o, active_o, waiting_o, chunk_end_o;
    logic        work_req_o, work_write_o, copy_req_o;
    logic [15:0] work_nsec_o, copy_len_o, sectors_left_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ide_dma_seq i_ide_dma_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
        .packet_i(packet_i), .sector_cnt_i(sector_cnt_i), .pkt_size_i(pkt_size_i),
        .pkt_lba_i(pkt_lba_i), .chunk_valid_i(chunk_valid_i), .chunk_len_i(chunk_len_i),
        .chunk_err_i(chunk_err_i), .status_rd_i(status_rd_i), .status_o(status_o),
        .irq_o(irq_o), .active_o(active_o), .waiting_o(waiting_o),
        .chunk_end_o(chunk_end_o), .work_req_o(work_req_o), .work_write_o(work_write_o),
        .work_nsec_o(work_nsec_o), .copy_req_o(copy_req_o), .copy_len_o(copy_len_o),
        .sectors_left_o(sectors_left_o)
    );

    // Reference model state
    int m_status, m_sec, m_rem, m_nsec, m_copy_len, m_cmd;
    bit m_irq, m_active, m_wait, m_end, m_work, m_wr, m_copy, m_pkt, m_nb;

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    // Model update on each rising edge
    always @(posedge clk) begin
        bit set;
        set = 0;
        if (!rst_n) begin
            m_status = 0; m_sec = 0; m_rem = 0; m_nsec = 0; m_copy_len = 0; m_cmd = 0;
            m_irq = 0; m_active = 0; m_wait = 0; m_end = 0; m_work = 0; m_wr = 0;
            m_copy = 0; m_pkt = 0; m_nb = 0;
        end else begin
            m_end = 0; m_work = 0; m_copy = 0;
            if (start_i && !m_active) begin
                m_cmd = cmd_i; m_pkt = packet_i; m_nb = packet_i && (pkt_lba_i == 32'hFFFF_FFFF);
                m_sec = sector_cnt_i;
                m_rem = packet_i ? int'(pkt_size_i) : int'(sector_cnt_i) * 512;
                m_status = 8'h80; m_active = 1; m_wait = 0;
            end else if (chunk_valid_i) begin
                if (chunk_err_i) begin
                    m_status = 8'h41; set = 1; m_active = 0; m_end = 1; m_rem = 0;
                end else if (!m_active) begin
                    m_wait = 1;
                end else if (m_rem <= 0) begin
                    m_status = m_pkt ? 8'h40 : 8'h50; set = 1; m_active = 0; m_end = 1;
                end else if (chunk_len_i == 0) begin
                    m_end = 1;
                end else if (m_pkt && m_nb) begin
                    m_copy = 1;
                    m_copy_len = (m_rem < int'(chunk_len_i)) ? m_rem : int'(chunk_len_i);
                    m_status = 8'h40; set = 1; m_active = 0; m_end = 1; m_rem = 0;
                end else begin
                    int n;
                    n = (int'(chunk_len_i) + 511) / 512;
                    m_rem = m_rem - int'(chunk_len_i);
                    if (!m_pkt) m_sec = (m_sec - n) & 16'hFFFF;
                    if (!m_pkt && m_cmd == 2) m_end = 1;
                    else begin
                        m_work = 1; m_nsec = n; m_wr = !m_pkt && (m_cmd == 1);
                    end
                end
            end
            m_irq = set || (m_irq && !status_rd_i);
        end
        started = 1;
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R5 status", status_o, m_status);
            chk("R11 irq", irq_o, m_irq);
            chk("R1 active", active_o, m_active);
            chk("R4 waiting", waiting_o, m_wait);
            chk("R12 chunk_end", chunk_end_o, m_end);
            chk("R7 work_req", work_req_o, m_work);
            chk("R7 work_nsec", work_nsec_o, m_nsec);
            chk("R7 work_write", work_write_o, m_wr);
            chk("R10 copy_req", copy_req_o, m_copy);
            chk("R10 copy_len", copy_len_o, m_copy_len);
            chk("R8 sectors_left", sectors_left_o, m_sec);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic do_start(input int cmd, input bit pkt, input int sec,
                            input int psize, input logic [31:0] lba);
        @(negedge clk);
        start_i = 1; cmd_i = 2'(cmd); packet_i = pkt; sector_cnt_i = 16'(sec);
        pkt_size_i = 25'(psize); pkt_lba_i = lba;
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic do_chunk(input int len, input bit err);
        @(negedge clk);
        chunk_valid_i = 1; chunk_len_i = 16'(len); chunk_err_i = err;
        @(negedge clk);
        chunk_valid_i = 0; chunk_err_i = 0;
    endtask

    task automatic do_read();
        @(negedge clk);
        status_rd_i = 1;
        @(negedge clk);
        status_rd_i = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset status", status_o, 0);

        // R4: completion while idle stalls, no end pulse
        do_chunk(512, 0);
        chk("R4 stalled", waiting_o, 1);
        chk("R4 no end", chunk_end_o, 0);

        // Disk read of 4 sectors with odd chunk lengths
        do_start(0, 0, 4, 0, 0);
        chk("R1 busy", status_o, 8'h80);
        chk("R4 cleared by start", waiting_o, 0);
        do_start(1, 0, 9, 0, 0);
        chk("R2 start ignored", sectors_left_o, 4);
        do_chunk(1024, 0);
        chk("R7 nsec 2", work_nsec_o, 2);
        do_chunk(0, 0);
        chk("R6 empty chunk end", chunk_end_o, 1);
        chk("R6 sectors kept", sectors_left_o, 2);
        do_chunk(700, 0);
        chk("R8 ceil sectors", sectors_left_o, 0);
        do_chunk(324, 0);
        do_chunk(100, 0);
        chk("R5 disk done", status_o, 8'h50);
        do_read();
        chk("R11 irq acked", irq_o, 0);

        // Disk write
        do_start(1, 0, 2, 0, 0);
        do_chunk(1024, 0);
        chk("R7 write flag", work_write_o, 1);
        do_chunk(0, 0);
        do_chunk(0, 0);

        // Disk trim: status read coincides with a new interrupt
        do_start(2, 0, 1, 0, 0);
        do_chunk(512, 0);
        chk("R8 trim no work", work_req_o, 0);
        @(negedge clk);
        chunk_valid_i = 1; chunk_len_i = 16'd0; status_rd_i = 1;
        @(negedge clk);
        chunk_valid_i = 0; status_rd_i = 0;
        chk("R11 set wins", irq_o, 1);
        do_read();

        // Error mid-command
        do_start(0, 0, 8, 0, 0);
        do_chunk(512, 0);
        do_chunk(512, 1);
        chk("R3 fault status", status_o, 8'h41);
        chk("R3 inactive", active_o, 0);
        do_read();

        // Packet block transfer, write code still reads
        do_start(1, 1, 7, 1000, 32'h10);
        do_chunk(1000, 0);
        chk("R9 read work", work_write_o, 0);
        chk("R9 sectors untouched", sectors_left_o, 7);
        do_chunk(0, 0);
        chk("R9 packet ok", status_o, 8'h40);
        do_read();

        // Non-block packet copies: size below and above chunk length
        do_start(0, 1, 0, 100, 32'hFFFF_FFFF);
        do_chunk(512, 0);
        chk("R10 copy min size", copy_len_o, 100);
        do_read();
        do_start(0, 1, 0, 600, 32'hFFFF_FFFF);
        do_chunk(200, 0);
        chk("R10 copy min len", copy_len_o, 200);
        do_read();

        // Start and completion together: start wins
        @(negedge clk);
        start_i = 1; cmd_i = 0; packet_i = 0; sector_cnt_i = 3; chunk_valid_i = 1; chunk_len_i = 512;
        @(negedge clk);
        start_i = 0; chunk_valid_i = 0;
        chk("R1 start wins", sectors_left_o, 3);
        do_chunk(0, 1);
        do_read();

        repeat (3) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule